// File: doc/BRIEF.md
# Quadrature Position Counter with Initialization Gate

The block keeps a 16-bit shaft position from two encoder phases, A and B, which arrive already synchronized and filtered. Every legal step of the two-bit Gray sequence moves the count up or down by one. The index input Z serves as a once-per-revolution check. The strobe input S is only reflected in status. Software uses a small register port to read the count, program a maximum count, pick the index behaviour and read status.

The unit does nothing until software writes the maximum count. Until then it reports itself as uninitialized, ignores the phase and index inputs, and keeps the count at zero. After that write, the count wraps within the range 0 to the maximum in both directions. On each rising edge of the index, the count is checked against the two legal values at a revolution boundary. A mismatch sets a sticky error flag and gives a one-cycle interrupt pulse. In realign mode, the index edge also forces the count to zero.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the count reads 0, the status reads 0x0004 when all four inputs are low (uninitialized flag set, error flag clear), and `err_irq_o` is low.
- R2: Status bit 2 reads 1 until the first write to the maximum-count register (address 1), and reads 0 from then on. While that bit is 1, phase steps and index edges change neither the count nor the error flag.
- R3: Phases are sampled as {A,B}. The order 00→10→11→01→00 adds one per step and the reverse order subtracts one per step. The new count is readable one clock after the edge that samples the changed inputs.
- R4: A sample in which A and B both differ from their previous values leaves the count unchanged.
- R5: An up step taken when the count is at or above the maximum count loads 0.
- R6: A down step taken when the count is 0 loads the maximum count.
- R7: A rising edge on Z after initialization, taken while the count is neither 0 nor the maximum count, sets status bit 0 and drives `err_irq_o` high for exactly one cycle. An index edge at 0 or at the maximum does neither. Status bit 0 stays set after Z falls.
- R8: Writing status (address 3) with data bit 0 at 1 clears the error flag. Writing status with data bit 0 at 0 leaves the flag set. A new error in the same cycle as a clear wins.
- R9: With control bit 0 set (address 2), a rising edge on Z after initialization loads 0 into the count. This edge takes priority over a phase step sampled in the same cycle.
- R10: Status bits 4, 5, 6 and 7 show the present levels of A, B, Z and S respectively.
- R11: `rdata_o` shows, without delay, the register selected by `addr_i`: 0 count, 1 maximum count, 2 control (bit 0), 3 status. Writes to address 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Filtered phase A |
| b_i | input | 1 | Filtered phase B |
| z_i | input | 1 | Filtered index |
| s_i | input | 1 | Filtered strobe, shown in status only |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for read and write |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Selected register contents |
| err_irq_o | output | 1 | One-cycle count-error interrupt |

## Verification
A wrong count or a lost step shows on the count register one clock after the sampling edge. From then on it stays wrong, because the position is only ever stepped from its last value. A bad wrap compare or a stale maximum puts a wrong value on the count at the very next boundary step. A broken index check makes the interrupt pulse appear, go missing or last too long, visible at the port one clock after the Z edge. A broken initialization gate shows as counting before the maximum is written, or as status bit 2 reading the wrong value right after that write.

// File: rtl/qc_pkg.sv
`timescale 1ns/1ps
package qc_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_COUNT = 2'd0,
    SEL_MAX   = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;

  localparam int ST_ERR    = 0;
  localparam int ST_UNINIT = 2;
  localparam int ST_LVL_A  = 4;
  localparam int ST_LVL_B  = 5;
  localparam int ST_LVL_Z  = 6;
  localparam int ST_LVL_S  = 7;
  localparam int ST_W      = 8;
endpackage

// File: rtl/qc_edge_detect.sv
`timescale 1ns/1ps
module qc_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  input  logic z_i,
  output logic up_o,
  output logic dn_o,
  output logic z_rise_o
);
  logic a_q, b_q, z_q;
  logic single;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
      z_q <= z_i;
    end
  end

  // exactly one phase moved: legal Gray step
  assign single   = (a_i ^ a_q) ^ (b_i ^ b_q);
  assign up_o     = single & (a_i ^ b_q);
  assign dn_o     = single & ~(a_i ^ b_q);
  assign z_rise_o = z_i & ~z_q;
endmodule

// File: rtl/qc_pos_counter.sv
`timescale 1ns/1ps
module qc_pos_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         z_rise_i,
  input  logic         realign_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] count_o,
  output logic         idx_bad_o
);
  logic [W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (en_i) begin
      if (z_rise_i && realign_i) count_d = '0;
      else if (up_i)             count_d = (count_q >= max_i) ? '0 : count_q + 1'b1;
      else if (dn_i)             count_d = (count_q == '0) ? max_i : count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o   = count_q;
  assign idx_bad_o = en_i & z_rise_i & (count_q != '0) & (count_q != max_i);
endmodule

// File: rtl/qc_regs.sv
`timescale 1ns/1ps
module qc_regs
  import qc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              idx_bad_i,
  output logic [W-1:0]      max_o,
  output logic              inited_o,
  output logic              realign_o,
  output logic              err_o,
  output logic              irq_o
);
  logic wr_max, wr_ctrl, wr_stat;

  assign wr_max  = we_i && (addr_i == SEL_MAX);
  assign wr_ctrl = we_i && (addr_i == SEL_CTRL);
  assign wr_stat = we_i && (addr_i == SEL_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_o     <= '0;
      inited_o  <= 1'b0;
      realign_o <= 1'b0;
    end else begin
      if (wr_max) begin
        max_o    <= wdata_i;
        inited_o <= 1'b1;
      end
      if (wr_ctrl) realign_o <= wdata_i[0];
    end
  end

  // sticky error, set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= idx_bad_i;
      if (idx_bad_i)                   err_o <= 1'b1;
      else if (wr_stat && wdata_i[0])  err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_pos_counter.sv
`timescale 1ns/1ps
module quad_pos_counter
  import qc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_i,
  input  logic              b_i,
  input  logic              z_i,
  input  logic              s_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              err_irq_o
);
  logic         step_up, step_dn, z_rise;
  logic         inited, realign, err_flag, idx_bad;
  logic [W-1:0] count, max_cnt;
  logic [ST_W-1:0] status;

  qc_edge_detect u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (a_i),
    .b_i      (b_i),
    .z_i      (z_i),
    .up_o     (step_up),
    .dn_o     (step_dn),
    .z_rise_o (z_rise)
  );

  qc_pos_counter #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (inited),
    .up_i      (step_up),
    .dn_i      (step_dn),
    .z_rise_i  (z_rise),
    .realign_i (realign),
    .max_i     (max_cnt),
    .count_o   (count),
    .idx_bad_o (idx_bad)
  );

  qc_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .idx_bad_i (idx_bad),
    .max_o     (max_cnt),
    .inited_o  (inited),
    .realign_o (realign),
    .err_o     (err_flag),
    .irq_o     (err_irq_o)
  );

  always_comb begin
    status            = '0;
    status[ST_ERR]    = err_flag;
    status[ST_UNINIT] = ~inited;
    status[ST_LVL_A]  = a_i;
    status[ST_LVL_B]  = b_i;
    status[ST_LVL_Z]  = z_i;
    status[ST_LVL_S]  = s_i;
  end

  always_comb begin
    unique case (addr_i)
      SEL_COUNT: rdata_o = count;
      SEL_MAX:   rdata_o = max_cnt;
      SEL_CTRL:  rdata_o = {{(W-1){1'b0}}, realign};
      default:   rdata_o = {{(W-ST_W){1'b0}}, status};
    endcase
  end
endmodule

// File: rtl/qc_checker.sv
`timescale 1ns/1ps
module qc_checker #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         a_i,
  input logic         b_i,
  input logic         inited,
  input logic         step_up,
  input logic         step_dn,
  input logic         z_rise,
  input logic         realign,
  input logic [W-1:0] count,
  input logic [W-1:0] max_cnt,
  input logic         err_flag,
  input logic         irq
);
  logic pa_q, pb_q;
  logic illegal, forced;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
    end else begin
      pa_q <= a_i;
      pb_q <= b_i;
    end
  end

  assign illegal = (a_i != pa_q) && (b_i != pb_q);
  assign forced  = z_rise && realign;

  a_r2_hold_uninit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inited |=> $stable(count));
  a_r3_one_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({step_up, step_dn}));
  a_r3_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inited && step_up && !forced && count < max_cnt) |=> count == $past(count) + 1'b1);
  a_r4_illegal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal && !forced) |=> $stable(count));
  a_r5_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inited && step_up && !forced && count == max_cnt) |=> count == '0);
  a_r6_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inited && step_dn && !forced && count == '0) |=> count == $past(max_cnt));
  a_r7_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |=> !irq);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> err_flag);
  a_r9_realign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inited && forced) |=> count == '0);
endmodule

bind quad_pos_counter qc_checker #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .b_i      (b_i),
  .inited   (inited),
  .step_up  (step_up),
  .step_dn  (step_dn),
  .z_rise   (z_rise),
  .realign  (realign),
  .count    (count),
  .max_cnt  (max_cnt),
  .err_flag (err_flag),
  .irq      (err_irq_o)
);

// File: tb/sim_quad_pos_counter.sv
`timescale 1ns/1ps
module sim_quad_pos_counter;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0, z = 1'b0, s = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int g = 0;

  always #2.5 clk = ~clk;

  quad_pos_counter #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .z_i(z), .s_i(s),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_irq_o(irq)
  );

  // reference model
  logic [W-1:0] m_cnt, m_max;
  logic m_init, m_mode, m_err, m_irq, m_pz;
  int m_pg;

  function automatic int gidx(logic pa, logic pb);
    case ({pa, pb})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_max = '0; m_init = 0; m_mode = 0; m_err = 0; m_irq = 0;
      m_pz = 0; m_pg = 0;
    end else begin
      int cur, d;
      bit zr, bad;
      cur = gidx(a, b);
      d = (cur - m_pg + 4) % 4;
      zr = z && !m_pz;
      bad = m_init && zr && (m_cnt != 0) && (m_cnt != m_max);
      if (m_init) begin
        if (zr && m_mode) m_cnt = '0;
        else if (d == 1) m_cnt = (m_cnt >= m_max) ? '0 : m_cnt + 1;
        else if (d == 3) m_cnt = (m_cnt == 0) ? m_max : m_cnt - 1;
      end
      m_irq = bad;
      if (bad) m_err = 1;
      else if (we && addr == 2'd3 && wdata[0]) m_err = 0;
      if (we && addr == 2'd1) begin m_max = wdata; m_init = 1; end
      if (we && addr == 2'd2) m_mode = wdata[0];
      m_pg = cur; m_pz = z;
    end
  end

  function automatic logic [W-1:0] m_rdata(logic [1:0] sel);
    case (sel)
      2'd0: return m_cnt;
      2'd1: return m_max;
      2'd2: return {{(W-1){1'b0}}, m_mode};
      default: return {{(W-8){1'b0}}, s, z, b, a, 1'b0, !m_init, 1'b0, m_err};
    endcase
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      chk("R11 rdata vs model", rdata, m_rdata(addr));
      chk("R7 irq vs model", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
    end
  end

  task automatic put_g();
    case (g)
      0: {a, b} = 2'b00;
      1: {a, b} = 2'b10;
      2: {a, b} = 2'b11;
      default: {a, b} = 2'b01;
    endcase
  endtask

  task automatic step(bit up, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      g = up ? (g + 1) % 4 : (g + 3) % 4;
      put_g();
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [W-1:0] val);
    @(negedge clk);
    we = 1; addr = sel; wdata = val;
    @(negedge clk);
    we = 0; addr = 2'd0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [W-1:0] val);
    @(negedge clk);
    addr = sel;
    #1;
    val = rdata;
  endtask

  task automatic zpulse(bit expect_irq, string tag);
    @(negedge clk);
    z = 1;
    @(negedge clk); #1;
    chk(tag, {15'd0, irq}, {15'd0, expect_irq});
    @(negedge clk); #1;
    chk(tag, {15'd0, irq}, 16'd0);
    z = 0;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(2'd0, v); chk("R1 count after reset", v, 16'd0);
    rd(2'd3, v); chk("R1 status after reset", v, 16'h0004);
    chk("R1 irq after reset", {15'd0, irq}, 16'd0);
    // R2 gate while uninitialized
    step(1, 2);
    rd(2'd0, v); chk("R2 no count while uninit", v, 16'd0);
    zpulse(0, "R2 no index error while uninit");
    rd(2'd3, v); chk("R10 levels A B, R2 uninit set", v, 16'h0034);
    wr(2'd1, 16'd5);
    rd(2'd1, v); chk("R11 max readback", v, 16'd5);
    rd(2'd3, v); chk("R2 uninit clears after max write", v, 16'h0030);
    // R3
    step(1, 3);
    rd(2'd0, v); chk("R3 up three steps", v, 16'd3);
    step(0, 1);
    rd(2'd0, v); chk("R3 down one step", v, 16'd2);
    // R4 illegal double change from 00 to 11
    @(negedge clk); g = 2; put_g();
    @(negedge clk);
    rd(2'd0, v); chk("R4 double change ignored", v, 16'd2);
    // R5 / R6
    step(1, 3);
    rd(2'd0, v); chk("R5 reach max", v, 16'd5);
    step(1, 1);
    rd(2'd0, v); chk("R5 wrap up to zero", v, 16'd0);
    step(0, 1);
    rd(2'd0, v); chk("R6 wrap down to max", v, 16'd5);
    // R7
    zpulse(0, "R7 index at max no error");
    rd(2'd3, v); chk("R7 no error at max", v & 16'h0001, 16'd0);
    step(0, 3);
    rd(2'd0, v); chk("R7 setup count", v, 16'd2);
    zpulse(1, "R7 index mismatch pulse");
    rd(2'd3, v); chk("R7 sticky after Z falls", v & 16'h0001, 16'd1);
    // R8
    wr(2'd3, 16'd0);
    rd(2'd3, v); chk("R8 write zero keeps flag", v & 16'h0001, 16'd1);
    wr(2'd3, 16'd1);
    rd(2'd3, v); chk("R8 write one clears flag", v & 16'h0001, 16'd0);
    // R10
    @(negedge clk); s = 1;
    rd(2'd3, v); chk("R10 strobe level", v & 16'h00F0, {8'd0, 1'b1, 1'b0, b, a, 4'd0});
    @(negedge clk); s = 0;
    rd(2'd3, v); chk("R10 strobe low", v & 16'h0080, 16'd0);
    // R9
    wr(2'd2, 16'd1);
    rd(2'd2, v); chk("R11 ctrl readback", v, 16'd1);
    zpulse(1, "R9 realign edge flags mismatch");
    rd(2'd0, v); chk("R9 realign to zero", v, 16'd0);
    step(1, 2);
    rd(2'd0, v); chk("R9 setup count", v, 16'd2);
    @(negedge clk);
    z = 1; g = (g + 1) % 4; put_g();
    @(negedge clk);
    z = 0;
    rd(2'd0, v); chk("R9 index beats step", v, 16'd0);
    // R11 count write ignored
    wr(2'd0, 16'h1234);
    rd(2'd0, v); chk("R11 count write ignored", v, 16'd0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule